// File: doc/BRIEF.md
# Weighted Hardware Thread Slot Scheduler

This block divides one system clock among eight hardware execution contexts. Every cycle belongs to exactly one context, and the owner of each cycle comes from a fixed 16-slot frame. A mode input chooses one of several bandwidth profiles. Each profile gives every context a power-of-two share of the clock, and that share's slots are spread evenly through the frame. Work inside a context therefore runs at its own fraction of the system clock. For example, with an 8 MHz clock in mode 0, context 0 advances at 4 MHz and context 1 advances at 1 MHz.

An eight-bit enable mask turns contexts on and off. A slot owned by a disabled context becomes an idle bubble and is not handed to any other context. The scheduler samples the mode only at the first slot of a frame, so a context never receives a partial frame under a mixed profile. The outputs are a one-hot grant vector and the index of the slot's owner. They feed the fetch and execute stages of a multi-context core, and both are valid in every cycle.

Top module: `ctx_slot_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, the frame position is slot 0, so `grant_idx_o` is 0 in every mode. Slots then advance by one per clock, in order 0 to 15, and wrap to 0.
- R2: `grant_o` always has at most one bit set. When it is nonzero, bit k is set only if `grant_idx_o` equals k.
- R3: In mode 0, the owners of slots 0 to 15 are 0,1,0,2,0,3,0,4,0,1,0,5,0,6,0,7. Per frame, context 0 gets 8 slots, context 1 gets 2 slots and contexts 2 to 7 get 1 slot each.
- R4: In mode 1, the owners of slots 0 to 15 are 0,2,1,4,0,3,1,5,0,2,1,6,0,3,1,7. Contexts 0 and 1 get 4 slots each, contexts 2 and 3 get 2 slots each and contexts 4 to 7 get 1 slot each.
- R5: In mode 2, the owner of slot s is s mod 8, so each context gets 2 slots per frame.
- R6: Mode values 3 to 7 produce exactly the same schedule as mode 2.
- R7: When the owner of a slot is disabled (bit k of `enable_i` is 0 for owner k), `grant_o` is all zeros for that cycle. `grant_idx_o` still shows the owner, and no other context's slots move or increase.
- R8: The mode applied to a whole frame is the value of `mode_i` in that frame's slot 0. Changes to `mode_i` in slots 1 to 15 have no effect until the next slot 0.
- R9: A context's consecutive grants within a profile are evenly spaced. With everything enabled, the gap is 16 divided by the context's slots per frame: 2 cycles for a 1/2 share, 4 for 1/4, 8 for 1/8 and 16 for 1/16.
- R10: The enable mask acts in the same cycle it is applied, with no frame alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Bandwidth profile select, sampled at slot 0 |
| enable_i | input | 8 | Per-context enable mask, bit k for context k |
| grant_o | output | 8 | One-hot issue grant, all zeros for a bubble |
| grant_idx_o | output | 3 | Owner of the current slot |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a frame. The ports do not show the frame position directly. The bench therefore counts slots from the release of reset, waits for a chosen slot, and changes `mode_i` there. It then expects the rest of that frame to follow the old profile and the next frame to follow the new one. A second reset is applied in mid-frame to confirm that the position restarts at slot 0. Masked runs combine the profiles with sparse enable patterns, so that bubbles land between the surviving grants and the per-context totals show that no slot was handed to another context.

// File: rtl/ctx_sched_pkg.sv
`timescale 1ns/1ps
package ctx_sched_pkg;
  localparam int CTX_N   = 8;
  localparam int CTX_W   = $clog2(CTX_N);
  localparam int FRAME_N = 16;
  localparam int POS_W   = $clog2(FRAME_N);
  localparam int MODE_W  = 3;

  typedef logic [CTX_W-1:0]  ctx_id_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_EQUAL = mode_t'(2);

  // Owner of a slot for a profile; the arithmetic spreads each share evenly.
  function automatic ctx_id_t slot_owner(input mode_t mode, input pos_t pos);
    logic [2:0] j;
    ctx_id_t    own;
    j = pos[3:1];
    case (mode)
      mode_t'(0): begin
        if (!pos[0])        own = ctx_id_t'(0);
        else if (j[1:0] == 2'd0) own = ctx_id_t'(1);
        else if (j < 3'd4)  own = ctx_id_t'(j + 3'd1);
        else                own = ctx_id_t'(j);
      end
      mode_t'(1): begin
        if (pos[1:0] == 2'd0)      own = ctx_id_t'(0);
        else if (pos[1:0] == 2'd2) own = ctx_id_t'(1);
        else if (!j[0])            own = ctx_id_t'(3'd2 + {2'b00, j[1]});
        else                       own = ctx_id_t'(3'd4 + {1'b0, j[2:1]});
      end
      default: own = ctx_id_t'(pos[2:0]);
    endcase
    return own;
  endfunction
endpackage

// File: rtl/ctx_frame_ctr.sv
`timescale 1ns/1ps
module ctx_frame_ctr #(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_start_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_q + 1'b1;
  end

  assign pos_o         = pos_q;
  assign frame_start_o = (pos_q == '0);
endmodule

// File: rtl/ctx_mode_hold.sv
`timescale 1ns/1ps
module ctx_mode_hold #(
  parameter int              MODE_W     = 3,
  parameter logic [MODE_W-1:0] RESET_MODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] act_mode_o
);
  logic [MODE_W-1:0] mode_q;

  assign act_mode_o = frame_start_i ? mode_i : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= RESET_MODE;
    else        mode_q <= act_mode_o;
  end
endmodule

// File: rtl/ctx_grant_mask.sv
`timescale 1ns/1ps
module ctx_grant_mask #(
  parameter int CTX_N = 8,
  parameter int CTX_W = 3
) (
  input  logic [CTX_W-1:0] owner_i,
  input  logic [CTX_N-1:0] enable_i,
  output logic [CTX_N-1:0] grant_o
);
  for (genvar k = 0; k < CTX_N; k++) begin : g_ctx
    assign grant_o[k] = (owner_i == CTX_W'(k)) && enable_i[k];
  end
endmodule

// File: rtl/ctx_slot_sched.sv
`timescale 1ns/1ps
module ctx_slot_sched
  import ctx_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CTX_N-1:0]  enable_i,
  output logic [CTX_N-1:0]  grant_o,
  output logic [CTX_W-1:0]  grant_idx_o
);
  pos_t    frame_pos;
  logic    frame_start;
  mode_t   act_mode;
  ctx_id_t owner;

  ctx_frame_ctr #(.POS_W(POS_W)) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .pos_o         (frame_pos),
    .frame_start_o (frame_start)
  );

  ctx_mode_hold #(.MODE_W(MODE_W), .RESET_MODE(MODE_EQUAL)) u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .mode_i        (mode_i),
    .act_mode_o    (act_mode)
  );

  always_comb owner = slot_owner(act_mode, frame_pos);

  ctx_grant_mask #(.CTX_N(CTX_N), .CTX_W(CTX_W)) u_mask (
    .owner_i  (owner),
    .enable_i (enable_i),
    .grant_o  (grant_o)
  );

  assign grant_idx_o = owner;
endmodule

// File: rtl/ctx_slot_sched_chk.sv
`timescale 1ns/1ps
module ctx_slot_sched_chk
  import ctx_sched_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTX_N-1:0]  enable_i,
  input logic [CTX_N-1:0]  grant_o,
  input logic [CTX_W-1:0]  grant_idx_o,
  input logic              frame_start,
  input logic [MODE_W-1:0] act_mode
);
  // R1
  first_slot_chk: assert property (@(posedge clk) !rst_n |=> grant_idx_o == '0);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R2
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (grant_o[grant_idx_o] && enable_i[grant_idx_o]));

  // R7
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i[grant_idx_o] |-> (grant_o == '0));

  // R8
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(act_mode));
endmodule

bind ctx_slot_sched ctx_slot_sched_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .grant_o     (grant_o),
  .grant_idx_o (grant_idx_o),
  .frame_start (frame_start),
  .act_mode    (act_mode)
);

// File: tb/ctx_slot_sched_tb.sv
`timescale 1ns/1ps
module ctx_slot_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [7:0] enable_i = 8'hFF;
  logic [7:0] grant_o;
  logic [2:0] grant_idx_o;

  always #4 clk = ~clk;

  ctx_slot_sched u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enable_i(enable_i),
    .grant_o(grant_o), .grant_idx_o(grant_idx_o)
  );

  // slot owners, slot 15 in the top nibble
  localparam logic [63:0] PAT0 = 64'h7060_5010_4030_2010;
  localparam logic [63:0] PAT1 = 64'h7130_6120_5130_4120;
  localparam logic [63:0] PAT2 = 64'h7654_3210_7654_3210;
  localparam int SH0 [8] = '{8, 2, 1, 1, 1, 1, 1, 1};
  localparam int SH1 [8] = '{4, 4, 2, 2, 1, 1, 1, 1};

  int tests = 0, fails = 0;
  int p = 0;
  int ncyc = 0;
  logic [2:0] fmode = 3'd2;
  int hits [8];
  int last [8];
  bit spacing_on = 0;

  function automatic int exp_owner(input logic [2:0] m, input int s);
    logic [63:0] pat;
    pat = (m == 3'd0) ? PAT0 : (m == 3'd1) ? PAT1 : PAT2;
    return int'(pat[s*4 +: 3]);
  endfunction

  function automatic int share(input logic [2:0] m, input int c);
    if (m == 3'd0) return SH0[c];
    if (m == 3'd1) return SH1[c];
    return 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic [2:0] m, input logic [7:0] en, input string req);
    int own;
    logic [7:0] eg;
    mode_i = m; enable_i = en;
    #1;
    if (p == 0) fmode = m;
    own = exp_owner(fmode, p);
    eg = en[own] ? (8'b1 << own) : 8'b0;
    check(grant_idx_o == 3'(own), req, $sformatf("idx slot %0d", p), grant_idx_o, own);
    check(grant_o == eg, req, $sformatf("grant slot %0d", p), grant_o, eg);
    if (grant_o != 0) begin
      if (spacing_on && last[grant_idx_o] >= 0)
        check(ncyc - last[grant_idx_o] == 16 / share(fmode, int'(grant_idx_o)),
              "R9", $sformatf("gap ctx %0d", grant_idx_o),
              ncyc - last[grant_idx_o], 16 / share(fmode, int'(grant_idx_o)));
      hits[grant_idx_o]++;
      last[grant_idx_o] = ncyc;
    end
    @(negedge clk);
    p = (p + 1) % 16;
    ncyc++;
  endtask

  task automatic align(input logic [2:0] m, input logic [7:0] en);
    while (p != 0) cycle(m, en, "R1");
  endtask

  task automatic clear_stats();
    for (int c = 0; c < 8; c++) begin hits[c] = 0; last[c] = -1; end
  endtask

  task automatic run_profile(input logic [2:0] m, input logic [7:0] en,
                             input int nfr, input string req);
    align(m, en);
    clear_stats();
    repeat (nfr * 16) cycle(m, en, req);
    for (int c = 0; c < 8; c++)
      check(hits[c] == (en[c] ? share(m, c) * nfr : 0), req,
            $sformatf("slot total ctx %0d mode %0d", c, m),
            hits[c], en[c] ? share(m, c) * nfr : 0);
  endtask

  task automatic t_reset();
    mode_i = 3'd1; enable_i = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    check(grant_idx_o == 3'd0, "R1", "idx in reset", grant_idx_o, 0);
    check(grant_o == 8'h01, "R1", "grant in reset", grant_o, 1);
    rst_n = 1'b1; p = 0;
    clear_stats();
    repeat (20) cycle(3'd2, 8'hFF, "R1");
  endtask

  task automatic t_mid_reset();
    while (p != 7) cycle(3'd0, 8'hFF, "R1");
    rst_n = 1'b0; mode_i = 3'd0;
    @(negedge clk); #1;
    check(grant_idx_o == 3'd0, "R1", "idx in mid-frame reset", grant_idx_o, 0);
    @(negedge clk);
    rst_n = 1'b1; p = 0;
    repeat (16) cycle(3'd0, 8'hFF, "R1");
  endtask

  task automatic t_boundary();
    align(3'd0, 8'hFF);
    repeat (5) cycle(3'd0, 8'hFF, "R8");
    repeat (11) cycle(3'd1, 8'hFF, "R8");   // ignored until slot 0
    repeat (16) cycle(3'd1, 8'hFF, "R8");
    repeat (3) cycle(3'd1, 8'hFF, "R8");
    repeat (13) cycle(3'd2, 8'hFF, "R8");
  endtask

  task automatic t_spacing(input logic [2:0] m);
    align(m, 8'hFF);
    clear_stats();
    spacing_on = 1;
    repeat (48) cycle(m, 8'hFF, "R9");
    spacing_on = 0;
  endtask

  task automatic t_mask_switch();
    align(3'd2, 8'hFF);
    clear_stats();
    repeat (4) cycle(3'd2, 8'hFF, "R10");
    repeat (4) cycle(3'd2, 8'h00, "R10");   // slots 4..7 become bubbles
    repeat (8) cycle(3'd2, 8'hFF, "R10");
    for (int c = 0; c < 8; c++)
      check(hits[c] == ((c >= 4) ? 1 : 2), "R10", $sformatf("hits ctx %0d", c),
            hits[c], (c >= 4) ? 1 : 2);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_profile(3'd0, 8'hFF, 4, "R3");
    run_profile(3'd1, 8'hFF, 4, "R4");
    run_profile(3'd2, 8'hFF, 4, "R5");
    run_profile(3'd3, 8'hFF, 2, "R6");
    run_profile(3'd7, 8'hFF, 2, "R6");
    run_profile(3'd0, 8'hFE, 3, "R7");
    run_profile(3'd1, 8'h5A, 3, "R7");
    run_profile(3'd2, 8'h81, 3, "R7");
    t_boundary();
    t_spacing(3'd0);
    t_spacing(3'd1);
    t_spacing(3'd2);
    t_mask_switch();
    t_mid_reset();
    run_profile(3'd1, 8'hFF, 1, "R2");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule